// File: doc/BRIEF.md
# Dual Legacy DMA Controller Register Front-End

This block holds the software-visible register state of two legacy-style DMA controllers and exposes it on an 8-bit I/O port bus. The first controller serves channels 0–3 and the second serves channels 4–7. Each channel owns a 16-bit base address register and a 16-bit word count register. Both are reached one byte at a time through 8-bit ports. A single byte-select toggle per controller decides whether a given access lands on the low or the high half.

Besides the per-channel words, each controller carries a command register, a 4-bit software request register (also visible as status), and a 4-bit channel mask. Three data-less command ports act on this state: reset the byte toggle, perform a full controller clear, or unmask every channel. The transfer engine, arbitration and page registers live elsewhere and use this block's state.

The first controller decodes addresses 00h–0Fh at a stride of one. The second decodes C0h–DEh at a stride of two, so it responds only to even addresses. Its register at local offset k sits at C0h + 2k. Read data is combinational and is zero whenever the read strobe is low. A cycle with the write strobe high is a write, even if the read strobe is also high. Every access takes effect on the rising clock edge where its strobe is sampled high.

Top module: `dma_legacy_regs`

## Requirements
- R1: A write of any data to the byte-toggle reset port (0Ch for controller 0, D8h for controller 1) makes that controller's next 16-bit register access use the low byte.
- R2: Each read or write of any channel's base address or word count register flips that controller's byte toggle. The toggle is shared by all of its channels and returns to the low byte after a high-byte access.
- R3: Channel n (0–3 within a controller) has its base address at local offset 2n and its word count at local offset 2n+1. These are ports 2n and 2n+1 for controller 0, and C0h+4n and C2h+4n for controller 1. A low-byte write followed by a high-byte write stores a 16-bit value, and two reads return it low byte first.
- R4: A write of any data to the full-clear port (0Dh / DAh) zeroes the command register, the request register and the byte toggle, and sets all four mask bits. Base and count registers keep their values.
- R5: A write of any data to the unmask port (0Eh / DCh) clears all four mask bits of that controller.
- R6: After reset, every mask bit is set, the command and request registers and all base and count registers are zero, and the byte toggle selects the low byte.
- R7: A read of any of the three command ports returns 00h and changes no state; in particular it does not flip the byte toggle.
- R8: The two controllers are independent. An access or command directed at one never changes the other's toggle, mask, command, request or channel registers.
- R9: Mask access works two ways. A write to the single-mask port (0Ah / D4h) sets or clears mask bit wdata[1:0] to the value of wdata[2]. A write to the all-mask port (0Fh / DEh) loads wdata[3:0] into the mask, and a read of that port returns {4'b0000, mask}.
- R10: A write to the request port (09h / D2h) sets or clears request bit wdata[1:0] to the value of wdata[2]. A write to the command port (08h / D0h) loads all 8 bits into the command register. A read of 08h / D0h returns status {request[3:0], 4'b0000}, and a read of 09h / D2h returns the command register.
- R11: io_rdata is 00h whenever io_rd is low, and also when the address matches no register. Offset 0Bh (0Bh / D6h) is unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe; one access per cycle it is high |
| io_wr | input | 1 | Write strobe; one access per cycle it is high |
| io_rdata | output | 8 | Combinational read data, zero when not reading |

## Verification
The bench sweeps every channel word of both controllers with distinct arithmetic values and reads them all back after the full sweep. A decoder that aliased the second controller's stride or swapped address and count would return another word. It interleaves byte accesses across channels to prove that one toggle is shared and wraps. A design that kept a toggle per channel, or failed to toggle on reads, would return the wrong half. Reads of the command ports are followed by word reads to expose a toggle flip or a clear triggered by a read. Commands issued to one controller are followed by a check of the other's mask, command and toggle, which catches decode overlap. Full clear is checked for clearing everything it should while preserving the channel words.

// File: rtl/dma_legacy_pkg.sv
package dma_legacy_pkg;

    localparam int NUM_CTRL    = 2;
    localparam int CH_PER_CTRL = 4;
    localparam int CH_W        = $clog2(CH_PER_CTRL);
    localparam int WORD_W      = 16;
    localparam int BYTE_W      = 8;
    localparam int OFF_W       = 4;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CHAN_ADDR,
        OP_CHAN_CNT,
        OP_CMD_STAT,
        OP_REQ,
        OP_SMASK,
        OP_CLRPTR,
        OP_MCLR,
        OP_CLRMASK,
        OP_ALLMASK
    } port_op_e;

    typedef struct packed {
        port_op_e        op;
        logic [CH_W-1:0] chan;
    } port_sel_t;

    typedef struct packed {
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] count;
    } chan_regs_t;

    // Window start of each controller on the I/O bus.
    function automatic logic [7:0] ctrl_base(input int idx);
        return (idx == 0) ? 8'h00 : 8'hC0;
    endfunction

    // log2 of the address stride of each controller.
    function automatic int ctrl_shift(input int idx);
        return (idx == 0) ? 0 : 1;
    endfunction

    function automatic port_sel_t decode_offset(input logic [OFF_W-1:0] off);
        port_sel_t s;
        s.chan = off[CH_W:1];
        s.op   = OP_NONE;
        if (!off[3]) begin
            s.op = off[0] ? OP_CHAN_CNT : OP_CHAN_ADDR;
        end else begin
            s.chan = '0;
            unique case (off[2:0])
                3'd0: s.op = OP_CMD_STAT;
                3'd1: s.op = OP_REQ;
                3'd2: s.op = OP_SMASK;
                3'd3: s.op = OP_NONE;
                3'd4: s.op = OP_CLRPTR;
                3'd5: s.op = OP_MCLR;
                3'd6: s.op = OP_CLRMASK;
                default: s.op = OP_ALLMASK;
            endcase
        end
        return s;
    endfunction

    function automatic logic is_cmd_port(input port_op_e op);
        return (op == OP_CLRPTR) || (op == OP_MCLR) || (op == OP_CLRMASK);
    endfunction

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
    import dma_legacy_pkg::*;
#(
    parameter int N_CTRL = NUM_CTRL
) (
    input  logic [7:0]       addr,
    output logic [N_CTRL-1:0] hit,
    output logic [OFF_W-1:0] off [N_CTRL]
);

    for (genvar g = 0; g < N_CTRL; g++) begin : g_win
        localparam int          SHIFT   = ctrl_shift(g);
        localparam logic [7:0]  BASE    = ctrl_base(g);
        localparam logic [7:0]  LOWMASK = 8'((1 << SHIFT) - 1);
        localparam int          TOPSH   = OFF_W + SHIFT;

        logic [7:0] shifted;
        logic       in_win;
        logic       aligned;

        assign shifted = addr >> SHIFT;
        assign in_win  = (addr >> TOPSH) == (BASE >> TOPSH);
        assign aligned = (addr & LOWMASK) == 8'h00;
        assign hit[g]  = in_win && aligned;
        assign off[g]  = shifted[OFF_W-1:0];
    end

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_legacy_pkg::*;
#(
    parameter int N_CH = CH_PER_CTRL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [OFF_W-1:0]  off,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd,
    input  logic              wr,
    output logic [BYTE_W-1:0] rdata
);

    localparam int MASK_W = N_CH;

    port_sel_t         sel;
    logic              wr_en;
    logic              rd_en;
    logic              word_op;
    logic              word_acc;
    logic              bptr_q;
    logic [BYTE_W-1:0] cmd_q;
    logic [MASK_W-1:0] req_q;
    logic [MASK_W-1:0] mask_q;
    chan_regs_t        chan_view [N_CH];
    logic [WORD_W-1:0] rd_word;

    assign sel      = decode_offset(off);
    assign wr_en    = hit && wr;
    assign rd_en    = hit && rd && !wr;
    assign word_op  = (sel.op == OP_CHAN_ADDR) || (sel.op == OP_CHAN_CNT);
    assign word_acc = (wr_en || rd_en) && word_op;

    // Shared byte-select toggle.
    always_ff @(posedge clk) begin
        if (rst) begin
            bptr_q <= 1'b0;
        end else if (wr_en && (sel.op == OP_CLRPTR || sel.op == OP_MCLR)) begin
            bptr_q <= 1'b0;
        end else if (word_acc) begin
            bptr_q <= ~bptr_q;
        end
    end

    // Per-channel base and count words.
    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        logic [WORD_W-1:0] base_q;
        logic [WORD_W-1:0] cnt_q;
        logic              mine;

        assign mine = wr_en && (sel.chan == CH_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                base_q <= '0;
                cnt_q  <= '0;
            end else if (mine && sel.op == OP_CHAN_ADDR) begin
                if (bptr_q) base_q[15:8] <= wdata;
                else        base_q[7:0]  <= wdata;
            end else if (mine && sel.op == OP_CHAN_CNT) begin
                if (bptr_q) cnt_q[15:8] <= wdata;
                else        cnt_q[7:0]  <= wdata;
            end
        end

        assign chan_view[g].base  = base_q;
        assign chan_view[g].count = cnt_q;
    end

    // Command register.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (wr_en && sel.op == OP_MCLR) begin
            cmd_q <= '0;
        end else if (wr_en && sel.op == OP_CMD_STAT) begin
            cmd_q <= wdata;
        end
    end

    // Software request bits.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (wr_en && sel.op == OP_MCLR) begin
            req_q <= '0;
        end else if (wr_en && sel.op == OP_REQ) begin
            req_q[wdata[CH_W-1:0]] <= wdata[2];
        end
    end

    // Channel mask.
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (wr_en) begin
            unique case (sel.op)
                OP_MCLR:    mask_q <= '1;
                OP_CLRMASK: mask_q <= '0;
                OP_SMASK:   mask_q[wdata[CH_W-1:0]] <= wdata[2];
                OP_ALLMASK: mask_q <= wdata[MASK_W-1:0];
                default:    mask_q <= mask_q;
            endcase
        end
    end

    // Read path.
    assign rd_word = (sel.op == OP_CHAN_CNT) ? chan_view[sel.chan].count
                                             : chan_view[sel.chan].base;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel.op)
                OP_CHAN_ADDR,
                OP_CHAN_CNT: rdata = bptr_q ? rd_word[15:8] : rd_word[7:0];
                OP_CMD_STAT: rdata = {req_q, 4'b0000};
                OP_REQ:      rdata = cmd_q;
                OP_ALLMASK:  rdata = {4'b0000, mask_q};
                default:     rdata = '0;
            endcase
        end
    end

    // R6
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (mask_q == '1 && !bptr_q && cmd_q == '0 && req_q == '0));

    // R4
    mclr_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel.op == OP_MCLR) |=> (mask_q == '1 && !bptr_q && cmd_q == '0 && req_q == '0));

    // R5
    clrmask_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel.op == OP_CLRMASK) |=> (mask_q == '0));

    // R1
    clrptr_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel.op == OP_CLRPTR) |=> !bptr_q);

    // R2
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        word_acc |=> (bptr_q != $past(bptr_q)));

    // R7
    cmd_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && is_cmd_port(sel.op)) |=> ($stable(bptr_q) && $stable(mask_q) && $stable(cmd_q) && $stable(req_q)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!hit) |=> ($stable(bptr_q) && $stable(mask_q) && $stable(cmd_q)));

endmodule

// File: rtl/dma_legacy_regs.sv
module dma_legacy_regs
    import dma_legacy_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] io_addr,
    input  logic [7:0] io_wdata,
    input  logic       io_rd,
    input  logic       io_wr,
    output logic [7:0] io_rdata
);

    logic [NUM_CTRL-1:0] hit;
    logic [OFF_W-1:0]    off   [NUM_CTRL];
    logic [BYTE_W-1:0]   rdata [NUM_CTRL];

    dma_port_decode #(.N_CTRL(NUM_CTRL)) u_decode (
        .addr (io_addr),
        .hit  (hit),
        .off  (off)
    );

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        dma_ctrl_regs #(.N_CH(CH_PER_CTRL)) u_regs (
            .clk   (clk),
            .rst   (rst),
            .hit   (hit[g]),
            .off   (off[g]),
            .wdata (io_wdata),
            .rd    (io_rd),
            .wr    (io_wr),
            .rdata (rdata[g])
        );
    end

    always_comb begin
        io_rdata = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            io_rdata = io_rdata | rdata[i];
        end
    end

    // R8
    single_ctrl_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    // R11
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> (io_rdata == 8'h00));

endmodule

// File: tb/tb_dma_legacy_regs.sv
module tb_dma_legacy_regs;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] io_addr = 8'h00;
    logic [7:0] io_wdata = 8'h00;
    logic       io_rd = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_word [2][4][2];
    logic [3:0]  m_mask [2];
    logic [3:0]  m_req  [2];
    logic [7:0]  m_cmd  [2];
    logic        m_ptr  [2];

    dma_legacy_regs dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] word_port(input int c, input int ch, input int k);
        return (c == 0) ? 8'(2*ch + k) : 8'(8'hC0 + 4*ch + 2*k);
    endfunction

    function automatic logic [7:0] loc_port(input int c, input int o);
        return (c == 0) ? 8'(o) : 8'(8'hC0 + 2*o);
    endfunction

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
        #2 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic word_wr(input int c, input int ch, input int k, input logic [7:0] d);
        bus_wr(word_port(c, ch, k), d);
        if (m_ptr[c]) m_word[c][ch][k][15:8] = d;
        else          m_word[c][ch][k][7:0]  = d;
        m_ptr[c] = !m_ptr[c];
    endtask

    task automatic word_wr16(input int c, input int ch, input int k, input logic [15:0] v);
        word_wr(c, ch, k, v[7:0]);
        word_wr(c, ch, k, v[15:8]);
    endtask

    task automatic word_rd_chk(input string rq, input int c, input int ch, input int k);
        logic [7:0] v;
        bus_rd(word_port(c, ch, k), v);
        chk(rq, v, m_ptr[c] ? m_word[c][ch][k][15:8] : m_word[c][ch][k][7:0]);
        m_ptr[c] = !m_ptr[c];
    endtask

    task automatic do_clrptr(input int c, input logic [7:0] d);
        bus_wr(loc_port(c, 12), d); m_ptr[c] = 1'b0;
    endtask

    task automatic do_mclr(input int c, input logic [7:0] d);
        bus_wr(loc_port(c, 13), d);
        m_cmd[c] = 8'h00; m_req[c] = 4'h0; m_mask[c] = 4'hF; m_ptr[c] = 1'b0;
    endtask

    task automatic do_clrmask(input int c, input logic [7:0] d);
        bus_wr(loc_port(c, 14), d); m_mask[c] = 4'h0;
    endtask

    task automatic ctrl_chk(input string rq, input int c);
        logic [7:0] v;
        bus_rd(loc_port(c, 15), v); chk({rq, " mask"}, v, {4'h0, m_mask[c]});
        bus_rd(loc_port(c, 8), v);  chk({rq, " status"}, v, {m_req[c], 4'h0});
        bus_rd(loc_port(c, 9), v);  chk({rq, " command"}, v, m_cmd[c]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int c = 0; c < 2; c++) begin
            m_mask[c] = 4'hF; m_req[c] = 4'h0; m_cmd[c] = 8'h00; m_ptr[c] = 1'b0;
            for (int ch = 0; ch < 4; ch++)
                for (int k = 0; k < 2; k++) m_word[c][ch][k] = 16'h0000;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R6: reset state of both controllers and words
        for (int c = 0; c < 2; c++) begin
            ctrl_chk("R6", c);
            for (int ch = 0; ch < 4; ch++) begin
                word_rd_chk("R6", c, ch, 0);
                word_rd_chk("R6", c, ch, 1);
            end
        end

        // R3: sweep every word with distinct values, read back after full sweep
        for (int c = 0; c < 2; c++) begin
            do_clrptr(c, 8'h00);
            for (int ch = 0; ch < 4; ch++)
                for (int k = 0; k < 2; k++)
                    word_wr16(c, ch, k, 16'((c*8 + ch*2 + k + 1) * 16'h1111 ^ 16'h5A00));
        end
        for (int c = 0; c < 2; c++)
            for (int ch = 0; ch < 4; ch++)
                for (int k = 0; k < 2; k++) begin
                    word_rd_chk("R3", c, ch, k);
                    word_rd_chk("R3", c, ch, k);
                end

        // R2: toggle shared across channels and registers, wraps
        for (int c = 0; c < 2; c++) begin
            do_clrptr(c, 8'h00);
            word_wr(c, 0, 0, 8'hA1);
            word_wr(c, 1, 1, 8'hB2);
            word_wr(c, 2, 0, 8'hC3);
            word_rd_chk("R2", c, 3, 1);
            word_rd_chk("R2", c, 0, 0);
            word_rd_chk("R2", c, 1, 1);
            word_rd_chk("R2", c, 2, 0);
        end

        // R1: clear pointer with several data values when pointer is high
        for (int c = 0; c < 2; c++)
            for (int d = 0; d < 4; d++) begin
                do_clrptr(c, 8'(d * 8'h55));
                word_rd_chk("R1", c, d, 0);
                do_clrptr(c, 8'(8'hFF - d));
                word_rd_chk("R1", c, d, 1);
            end

        // R7: reads of command ports return zero and change nothing
        for (int c = 0; c < 2; c++) begin
            bus_wr(loc_port(c, 15), 8'h05); m_mask[c] = 4'h5;
            bus_wr(loc_port(c, 8), 8'h3C);  m_cmd[c] = 8'h3C;
            do_clrptr(c, 8'h00);
            word_rd_chk("R7", c, 1, 0);
            for (int o = 12; o < 15; o++) begin
                bus_rd(loc_port(c, o), v);
                chk("R7 readzero", v, 8'h00);
            end
            word_rd_chk("R7", c, 1, 0);
            ctrl_chk("R7", c);
        end

        // R11: unmapped offset and idle read data
        for (int c = 0; c < 2; c++) begin
            bus_rd(loc_port(c, 11), v); chk("R11 unmapped", v, 8'h00);
        end
        bus_rd(8'h41, v); chk("R11 outside", v, 8'h00);
        bus_rd(8'hC1, v); chk("R11 odd", v, 8'h00);
        @(negedge clk); io_addr = 8'h02; #2 chk("R11 idle", io_rdata, 8'h00);

        // R9: single mask and all-mask sweeps
        for (int c = 0; c < 2; c++) begin
            for (int m = 0; m < 16; m++) begin
                bus_wr(loc_port(c, 15), 8'(8'hF0 | m)); m_mask[c] = 4'(m);
                bus_rd(loc_port(c, 15), v); chk("R9 allmask", v, 8'(m));
            end
            for (int ch = 0; ch < 4; ch++)
                for (int s = 0; s < 2; s++) begin
                    bus_wr(loc_port(c, 10), 8'(8'hF8 & ~(s == 0 ? 8'h04 : 8'h00) | 8'(ch) | 8'(s*4)));
                    m_mask[c][ch] = s[0];
                    bus_rd(loc_port(c, 15), v); chk("R9 single", v, {4'h0, m_mask[c]});
                end
        end

        // R10: request bits and command register
        for (int c = 0; c < 2; c++) begin
            for (int ch = 0; ch < 4; ch++) begin
                bus_wr(loc_port(c, 9), 8'(8'h04 | ch)); m_req[c][ch] = 1'b1;
                ctrl_chk("R10 reqset", c);
            end
            bus_wr(loc_port(c, 9), 8'h01); m_req[c][1] = 1'b0;
            ctrl_chk("R10 reqclr", c);
            for (int k = 0; k < 4; k++) begin
                bus_wr(loc_port(c, 8), 8'(8'h81 + k*37)); m_cmd[c] = 8'(8'h81 + k*37);
                ctrl_chk("R10 cmd", c);
            end
        end

        // R4: full clear, channel words preserved
        for (int c = 0; c < 2; c++) begin
            bus_wr(loc_port(c, 15), 8'h00); m_mask[c] = 4'h0;
            bus_wr(loc_port(c, 9), 8'h06);  m_req[c][2] = 1'b1;
            word_wr(c, 2, 1, 8'h77);
            do_mclr(c, 8'h00);
            ctrl_chk("R4", c);
            word_rd_chk("R4", c, 2, 1);
            word_rd_chk("R4", c, 2, 1);
        end

        // R5: unmask
        for (int c = 0; c < 2; c++) begin
            do_clrmask(c, 8'hA5);
            ctrl_chk("R5", c);
        end

        // R8: independence of controllers
        bus_wr(loc_port(0, 15), 8'h09); m_mask[0] = 4'h9;
        bus_wr(loc_port(1, 15), 8'h06); m_mask[1] = 4'h6;
        bus_wr(loc_port(0, 8), 8'h12);  m_cmd[0] = 8'h12;
        bus_wr(loc_port(1, 8), 8'h34);  m_cmd[1] = 8'h34;
        do_clrptr(0, 8'h00); do_clrptr(1, 8'h00);
        word_wr(0, 0, 0, 8'h11);
        do_mclr(1, 8'h00);
        do_clrptr(1, 8'h00);
        ctrl_chk("R8 c0", 0);
        word_rd_chk("R8 c0ptr", 0, 3, 0);
        do_clrmask(0, 8'h00);
        ctrl_chk("R8 c1", 1);
        word_wr(1, 3, 1, 8'h99);
        do_mclr(0, 8'h00);
        word_rd_chk("R8 c1ptr", 1, 3, 1);
        ctrl_chk("R8 c1b", 1);
        for (int c = 0; c < 2; c++)
            for (int ch = 0; ch < 4; ch++) begin
                do_clrptr(c, 8'h00);
                word_rd_chk("R8 words", c, ch, 0);
                word_rd_chk("R8 words", c, ch, 0);
            end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule